// File: doc/BRIEF.md
# MDIO Management Controller

This block lets software on a 32-bit register bus run clause-22 management transactions against an external PHY. The system clock is divided to produce MDC, and each transaction is shifted out serially on a tri-state MDIO pin, which appears as separate output, output-enable and input signals. Software loads the PHY and register addresses and any write data, then starts a read, a write or a scan through strobes in the command register. It polls the busy flag until it clears, collects read data from the receive-data register, and finally writes zero to the command register.

In scan mode the controller reads the addressed register again and again. After each complete read it refreshes a link-fail flag from bit 2 of the returned value. An invalid flag stays set until the first scan read has finished. The 32-bit preamble of ones can be suppressed to shorten every frame.

Top module: `mdio_ctrl`

## Requirements
- R1: Mode register (select 0) bits [7:0] hold the clock divider and bit 0 always reads back as 0. MDC has a period of that many system clocks, with a value of 0 behaving as 2. Bit 8 set suppresses the preamble.
- R2: A frame is, MSB first: 32 ones (omitted when mode bit 8 is set), start 01, opcode (10 read, 01 write), 5-bit PHY address, 5-bit register address, turnaround (10 on writes), then 16 data bits. A frame is therefore 64 bits long, or 32 bits without preamble.
- R3: MDIO output changes only on a falling MDC edge. Every bit is valid at the following rising MDC edge, which is also where read data is sampled.
- R4: During a read, the output enable is released from the first turnaround bit to the end of the frame. The 16 bits sampled in the data phase appear in bits [15:0] of the receive-data register (select 4).
- R5: Command register (select 1): bit 0 scan, bit 1 read, bit 2 write, with scan taking priority over read and read over write. A command is accepted only when not busy; one written while busy starts no frame.
- R6: Status register (select 5) bit 1 (busy) reads 1 from the cycle after a command is accepted. It returns to 0 after the rising MDC edge of the final frame bit and before the next rising edge.
- R7: In scan mode, read frames repeat while command bit 0 stays set. Status bit 0 (link fail) equals the inverse of bit 2 of the latest scan value. Status bit 2 (invalid) is set on acceptance and clears when the first scan frame completes. Clearing command bit 0 ends scanning after the current frame, and busy then clears.
- R8: The address register (select 2) holds the PHY address in [4:0] and the register address in [12:8]. Transmit data (select 3) occupies [15:0]. After reset the mode register holds the reset divider with bit 0 cleared, and all other registers, all status flags and the output enable are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_sel_i | input | 3 | Register select |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational) |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output data |
| mdio_oe_o | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO input data |

## Verification
The bench builds the block with DIV_RST set to 4. A 64-bit frame then takes only 256 system clocks, which leaves room for frames with and without preamble, several scan rounds and divider changes to 0, 5 and 6. A PHY model in the bench counts MDC rising edges from the start of each frame and drives read data on falling edges. This lets the bench check the position of every bit, the release of the output enable and the exact point where busy drops. Counting frame starts exposes commands that should have been ignored and scans that should have stopped.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = 32;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int SEL_W      = 3;

  localparam logic [SEL_W-1:0] SEL_MODE   = 3'd0;
  localparam logic [SEL_W-1:0] SEL_CMD    = 3'd1;
  localparam logic [SEL_W-1:0] SEL_ADDR   = 3'd2;
  localparam logic [SEL_W-1:0] SEL_TXD    = 3'd3;
  localparam logic [SEL_W-1:0] SEL_RXD    = 3'd4;
  localparam logic [SEL_W-1:0] SEL_STATUS = 3'd5;

  function automatic logic [FRAME_BITS-1:0] build_frame(
    input logic rd, input logic [ADDR_W-1:0] phy,
    input logic [ADDR_W-1:0] rg, input logic [DATA_W-1:0] d);
    return {2'b01, (rd ? 2'b10 : 2'b01), phy, rg,
            (rd ? 2'b00 : 2'b10), (rd ? {DATA_W{1'b0}} : d)};
  endfunction
endpackage

// File: rtl/mdio_clk_gen.sv
module mdio_clk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  localparam int HW = DIV_W - 1;

  logic [HW-1:0] cnt_q;
  logic [HW-1:0] half;
  logic          mdc_q;
  logic          tick;

  always_comb begin
    half = div_i[DIV_W-1:1];
    if (half == '0) half = HW'(1);
  end

  assign tick   = (cnt_q >= half - HW'(1));
  assign rise_o = tick & ~mdc_q;
  assign fall_o = tick &  mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + HW'(1);
    end
  end

  AST_EDGE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !mdc_q); // R1
endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdc_i,
  input  logic              start_i,
  input  logic              rd_i,
  input  logic              nopre_i,
  input  logic [ADDR_W-1:0] phy_i,
  input  logic [ADDR_W-1:0] reg_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int CW = $clog2(PRE_BITS + FRAME_BITS);
  localparam int TA_IDX   = 2 * ADDR_W + 4;
  localparam int DATA_IDX = FRAME_BITS - DATA_W;

  logic [FRAME_BITS-1:0] frame_q;
  logic [DATA_W-1:0]     rx_q;
  logic [CW-1:0]         cur_q;
  logic [CW-1:0]         last;
  logic [CW-1:0]         fidx;
  logic                  pend_q, act_q, rd_q, nopre_q;
  logic                  is_pre;

  assign last   = nopre_q ? CW'(FRAME_BITS - 1) : CW'(PRE_BITS + FRAME_BITS - 1);
  assign is_pre = !nopre_q && (cur_q < CW'(PRE_BITS));
  assign fidx   = nopre_q ? cur_q : cur_q - CW'(PRE_BITS);

  always_comb begin
    mdio_o    = 1'b0;
    mdio_oe_o = 1'b0;
    if (act_q) begin
      if (is_pre) begin
        mdio_o    = 1'b1;
        mdio_oe_o = 1'b1;
      end else begin
        mdio_o    = frame_q[FRAME_BITS-1-int'(fidx[$clog2(FRAME_BITS)-1:0])];
        mdio_oe_o = !rd_q || (fidx < CW'(TA_IDX));
      end
    end
  end

  assign done_o  = act_q && fall_i && (cur_q == last);
  assign busy_o  = pend_q | act_q;
  assign rdata_o = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q <= '0;
      rx_q    <= '0;
      cur_q   <= '0;
      pend_q  <= 1'b0;
      act_q   <= 1'b0;
      rd_q    <= 1'b0;
      nopre_q <= 1'b0;
    end else begin
      if (start_i) begin
        pend_q  <= 1'b1;
        rd_q    <= rd_i;
        nopre_q <= nopre_i;
        frame_q <= build_frame(rd_i, phy_i, reg_i, wdata_i);
      end
      if (fall_i) begin
        if (pend_q && !act_q) begin
          pend_q <= 1'b0;
          act_q  <= 1'b1;
          cur_q  <= '0;
        end else if (act_q) begin
          if (cur_q == last) act_q <= 1'b0;
          else               cur_q <= cur_q + CW'(1);
        end
      end
      if (rise_i && act_q && rd_q && !is_pre && fidx >= CW'(DATA_IDX))
        rx_q <= {rx_q[DATA_W-2:0], mdio_i};
    end
  end

  AST_DRIVE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mdio_o != $past(mdio_o)) |-> (!mdc_i && $past(mdc_i))); // R3
  AST_RD_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_q && rd_q && !is_pre && fidx >= CW'(TA_IDX)) |-> !mdio_oe_o); // R4
  AST_DONE_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !mdc_i); // R6
endmodule

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int                DIV_W   = 8,
  parameter logic [DIV_W-1:0]  DIV_RST = 8'd64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [2:0]       reg_sel_i,
  input  logic             reg_we_i,
  input  logic [31:0]      reg_wdata_i,
  output logic [31:0]      reg_rdata_o,
  output logic             mdc_o,
  output logic             mdio_o,
  output logic             mdio_oe_o,
  input  logic             mdio_i
);
  logic [DIV_W-1:0]  div_q;
  logic              nopre_q;
  logic [2:0]        cmd_q;
  logic [ADDR_W-1:0] phy_q, rga_q;
  logic [DATA_W-1:0] tx_q, rx_q;
  logic              busy_q, scan_q, link_fail_q, invalid_q;

  logic rise, fall, seq_busy, seq_done, accept, start, start_rd;
  logic [DATA_W-1:0] seq_rdata;

  mdio_clk_gen #(.DIV_W(DIV_W)) u_clk (
    .clk_i, .rst_ni, .div_i(div_q), .mdc_o, .rise_o(rise), .fall_o(fall));

  assign accept   = reg_we_i && (reg_sel_i == SEL_CMD) && !busy_q && (|reg_wdata_i[2:0]);
  assign start    = accept || (seq_done && scan_q && cmd_q[0]);
  // scan > read > write; scan frames are reads
  assign start_rd = accept ? (reg_wdata_i[0] | reg_wdata_i[1]) : 1'b1;

  mdio_frame_seq u_seq (
    .clk_i, .rst_ni, .rise_i(rise), .fall_i(fall), .mdc_i(mdc_o),
    .start_i(start), .rd_i(start_rd), .nopre_i(nopre_q),
    .phy_i(phy_q), .reg_i(rga_q), .wdata_i(tx_q), .mdio_i,
    .mdio_o, .mdio_oe_o, .busy_o(seq_busy), .done_o(seq_done),
    .rdata_o(seq_rdata));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q       <= {DIV_RST[DIV_W-1:1], 1'b0};
      nopre_q     <= 1'b0;
      cmd_q       <= '0;
      phy_q       <= '0;
      rga_q       <= '0;
      tx_q        <= '0;
      rx_q        <= '0;
      busy_q      <= 1'b0;
      scan_q      <= 1'b0;
      link_fail_q <= 1'b0;
      invalid_q   <= 1'b0;
    end else begin
      if (seq_done) begin
        rx_q <= seq_rdata;
        if (scan_q) begin
          link_fail_q <= ~seq_rdata[2];
          invalid_q   <= 1'b0;
          if (!cmd_q[0]) begin
            busy_q <= 1'b0;
            scan_q <= 1'b0;
          end
        end else begin
          busy_q <= 1'b0;
        end
      end
      if (reg_we_i) begin
        unique case (reg_sel_i)
          SEL_MODE: begin
            div_q   <= {reg_wdata_i[DIV_W-1:1], 1'b0};
            nopre_q <= reg_wdata_i[8];
          end
          SEL_CMD:  cmd_q <= reg_wdata_i[2:0];
          SEL_ADDR: begin
            phy_q <= reg_wdata_i[4:0];
            rga_q <= reg_wdata_i[12:8];
          end
          SEL_TXD:  tx_q <= reg_wdata_i[DATA_W-1:0];
          default: ;
        endcase
      end
      if (accept) begin
        busy_q <= 1'b1;
        scan_q <= reg_wdata_i[0];
        if (reg_wdata_i[0]) invalid_q <= 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_sel_i)
      SEL_MODE:   reg_rdata_o = {23'd0, nopre_q, div_q};
      SEL_CMD:    reg_rdata_o = {29'd0, cmd_q};
      SEL_ADDR:   reg_rdata_o = {19'd0, rga_q, 3'd0, phy_q};
      SEL_TXD:    reg_rdata_o = {16'd0, tx_q};
      SEL_RXD:    reg_rdata_o = {16'd0, rx_q};
      SEL_STATUS: reg_rdata_o = {29'd0, invalid_q, busy_q, link_fail_q};
      default:    reg_rdata_o = '0;
    endcase
  end

  AST_IDLE_NO_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !seq_busy); // R6
  AST_INVALID_IN_SCAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_q |-> (busy_q && scan_q)); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_q && !seq_done) |=> !$rose(seq_busy)); // R5
endmodule

// File: tb/mdio_ctrl_tb.sv
module mdio_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 4;

  // {rd, nopre, phy[5], reg[5], wdata[16], resp[16]}
  localparam logic [43:0] VEC [NVEC] = '{
    {1'b0, 1'b0, 5'h01, 5'h00, 16'hA5C3, 16'h0000},
    {1'b1, 1'b0, 5'h1F, 5'h1F, 16'h0000, 16'h1234},
    {1'b0, 1'b1, 5'h12, 5'h0A, 16'hFFFF, 16'h0000},
    {1'b1, 1'b1, 5'h05, 5'h11, 16'h0000, 16'h8001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  sel = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        mdc, mdo, moe;
  logic        mdi = 1'b0;

  int checks = 0, fails = 0;
  int n = 0, frames = 0, off = 32;
  logic prev_oe = 1'b0;
  logic cap_o [128];
  logic cap_oe [128];
  logic [15:0] resp = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_ctrl #(.DIV_RST(8'd4)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(sel), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .mdc_o(mdc),
    .mdio_o(mdo), .mdio_oe_o(moe), .mdio_i(mdi));

  // PHY model
  always @(posedge mdc) begin
    if (moe && !prev_oe) begin n = 0; frames++; end
    if (n < 128) begin cap_o[n] = mdo; cap_oe[n] = moe; end
    n++;
    prev_oe = moe;
  end
  always @(negedge mdc) begin
    if (n >= off + 16 && n <= off + 31) mdi = resp[15 - (n - off - 16)];
    else mdi = 1'b0;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); sel = s; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    @(negedge clk); sel = s; #1 d = rdata;
  endtask

  task automatic wait_idle(output int at_n);
    logic [31:0] st;
    at_n = -1;
    for (int i = 0; i < 20000; i++) begin
      rd(3'd5, st);
      if (!st[1]) begin at_n = n; break; end
    end
  endtask

  function automatic logic [31:0] exp_frame(logic r, logic [4:0] p, logic [4:0] g, logic [15:0] d);
    logic [31:0] f;
    f[31:30] = 2'b01;
    f[29:28] = r ? 2'b10 : 2'b01;
    f[27:23] = p;
    f[22:18] = g;
    f[17:16] = r ? 2'b00 : 2'b10;
    f[15:0]  = r ? 16'h0 : d;
    return f;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] v, f;
    int end_n, tot, bad_bits, bad_oe, fcnt;
    realtime t0, t1;

    // reset state
    #1 chk("R8 oe in reset", {31'd0, moe}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(3'd0, v); chk("R8 mode reset", v, 32'h4);
    rd(3'd5, v); chk("R8 status reset", v, 32'h0);
    rd(3'd4, v); chk("R8 rx reset", v, 32'h0);

    // table-driven frames
    for (int k = 0; k < NVEC; k++) begin
      logic r, np; logic [4:0] p, g; logic [15:0] d, rs;
      {r, np, p, g, d, rs} = VEC[k];
      off = np ? 0 : 32;
      tot = off + 32;
      resp = rs;
      wr(3'd0, {23'd0, np, 8'd4});
      wr(3'd2, {19'd0, g, 3'd0, p});
      rd(3'd2, v); chk("R8 address readback", v, {19'd0, g, 3'd0, p});
      wr(3'd3, {16'd0, d});
      wr(3'd1, r ? 32'h2 : 32'h4);
      rd(3'd5, v); chk("R6 busy after accept", {31'd0, v[1]}, 32'd1);
      wait_idle(end_n);
      chk("R6 busy end after last bit", end_n, tot);
      f = exp_frame(r, p, g, d);
      bad_bits = 0; bad_oe = 0;
      for (int b = 0; b < tot; b++) begin
        logic eo, eoe;
        eo  = (b < off) ? 1'b1 : f[31 - (b - off)];
        eoe = !r || (b < off + 14);
        if (cap_oe[b] !== eoe) bad_oe++;
        if (eoe && cap_o[b] !== eo) bad_bits++;
      end
      chk("R2 R3 frame bits", bad_bits, 0);
      chk("R4 oe pattern", bad_oe, 0);
      if (r) begin
        rd(3'd4, v); chk("R4 read data", v, {16'd0, rs});
      end
      wr(3'd1, 32'h0);
    end

    // command while busy is ignored
    off = 32; resp = 16'h00F0;
    wr(3'd0, 32'h4);
    fcnt = frames;
    wr(3'd1, 32'h2);
    repeat (20) @(negedge clk);
    wr(3'd1, 32'h4);
    wait_idle(end_n);
    repeat (200) @(negedge clk);
    chk("R5 one frame only", frames - fcnt, 1);
    chk("R5 frame stayed a read", {31'd0, cap_oe[60]}, 32'd0);
    rd(3'd4, v); chk("R5 read data kept", v, 32'h00F0);
    wr(3'd1, 32'h0);

    // priority: read + write -> read
    resp = 16'h0F0F;
    wr(3'd1, 32'h6);
    wait_idle(end_n);
    rd(3'd4, v); chk("R5 read wins over write", v, 32'h0F0F);
    wr(3'd1, 32'h0);

    // divider
    wr(3'd0, 32'h5);
    rd(3'd0, v); chk("R1 bit0 forced low", v, 32'h4);
    @(posedge mdc); t0 = $realtime; @(posedge mdc); t1 = $realtime;
    chk("R1 period div4", int'((t1 - t0) / CLK_PERIOD), 4);
    wr(3'd0, 32'h6);
    @(posedge mdc); @(posedge mdc); t0 = $realtime; @(posedge mdc); t1 = $realtime;
    chk("R1 period div6", int'((t1 - t0) / CLK_PERIOD), 6);
    wr(3'd0, 32'h0);
    @(posedge mdc); @(posedge mdc); t0 = $realtime; @(posedge mdc); t1 = $realtime;
    chk("R1 period div0", int'((t1 - t0) / CLK_PERIOD), 2);
    wr(3'd0, 32'h104);
    rd(3'd0, v); chk("R1 nopre bit", v, 32'h104);

    // scan
    off = 0; resp = 16'hFFFB;
    wr(3'd2, 32'h0101);
    wr(3'd1, 32'h1);
    rd(3'd5, v); chk("R7 invalid and busy on scan", v & 32'h6, 32'h6);
    for (int i = 0; i < 5000; i++) begin rd(3'd5, v); if (!v[2]) break; end
    chk("R7 invalid cleared", {31'd0, v[2]}, 32'd0);
    chk("R7 link fail set", {31'd0, v[0]}, 32'd1);
    chk("R7 still busy", {31'd0, v[1]}, 32'd1);
    resp = 16'h0004;
    for (int i = 0; i < 5000; i++) begin rd(3'd5, v); if (!v[0]) break; end
    chk("R7 link fail cleared", {31'd0, v[0]}, 32'd0);
    fcnt = frames;
    repeat (300) @(negedge clk);
    chk("R7 scan repeats", {31'd0, frames > fcnt}, 32'd1);
    wr(3'd1, 32'h0);
    wait_idle(end_n);
    chk("R7 scan stops busy", {31'd0, end_n >= 0}, 32'd1);
    fcnt = frames;
    repeat (300) @(negedge clk);
    chk("R7 no frames after stop", frames - fcnt, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule